// File: doc/BRIEF.md
# Two-level page table walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table in memory. Each level is indexed by 10 bits of the address, each entry is 4 bytes, and pages are 4 KiB. A caller gives one request. The request carries the access kind (fetch, load or store), the privilege level, the machine-mode override controls, the user-memory access and executable-readable controls, the root table page number and a translation-enable bit. The walker then reads entries through a single request/acknowledge memory port. At the end it returns one response: a physical address, read/write/execute permissions and a fault flag.

Before it reports success, the walker makes sure the entry's accessed bit is set, and for stores the dirty bit as well. It does this with a compare-and-swap request. The memory writes the new value only if the entry still holds the value the walker read, and it always returns the value it found. If that returned value differs, another agent changed the entry in the meantime. The walker then starts the whole walk again from the root table.

Top module: `pgwalk`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid` and `memReq` are 0. Each accepted request produces exactly one single-cycle `rspValid` pulse, and `reqReady` returns to 1 in the following cycle.
- R2: The address passes through untranslated in two cases: `reqXlate` is 0, or the effective privilege is machine (encoding 3). In both cases `rspPaddr` is the zero-extended virtual address, read, write and execute are all 1, there is no fault, and no memory transaction is issued.
- R3: The effective privilege is `reqPrevPriv` for a machine-mode (`reqPriv`=3) load or store with `reqModPriv`=1. Otherwise it is `reqPriv`. A fetch (access code 0) ignores `reqModPriv`. Load is code 1 and store is code 2. Privilege codes are 0 for user and 1 for supervisor.
- R4: Each entry is read at base + index*4. The first read uses base = root page number * 4096 and index = vaddr[31:22]. An entry with V set and R, W and X all clear is a pointer. The next read then uses base = its page number * 4096 and index = vaddr[21:12]. Entry bits: V=0, R=1, W=2, X=3, U=4, A=6, D=7, page number in bits [31:10].
- R5: The walk ends in a fault in three cases: an entry with V clear, a pointer found at the second level, or a memory response with `memErr` set.
- R6: A leaf with W set and R clear faults, with X either clear or set.
- R7: A leaf with U set faults when the effective privilege is not user and either `reqSum` is 0 or the access is a fetch. A leaf with U clear faults unless the effective privilege is supervisor.
- R8: A leaf found at the first level faults if bits [9:0] of its page number are not zero.
- R9: A load needs R, or X together with `reqMxr`. A store needs W. A fetch needs X. Otherwise the access faults.
- R10: A permitted leaf that lacks A, or lacks D on a store, causes one compare-and-swap write. That write has `memCmp` set to the entry as read and `memWdata` set to the entry with A set, plus D for a store. A leaf that needs no change causes no write. If the returned data differs from `memCmp`, the walker restarts from the root.
- R11: On success, `rspPaddr` is the leaf page number * 4096 plus vaddr[11:0]. For a first-level leaf, the low 10 page-number bits come from vaddr[21:12]. `rspRead` is R or (X and `reqMxr`). `rspExec` is X. `rspWrite` is W, and only when the access is a store or D is already set.
- R12: A faulting response has `rspFault` 1, `rspPaddr` 0 and all three permissions 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when `reqReady` is 1 |
| reqReady | output | 1 | Walker idle, able to take a request |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 fetch, 1 load, 2 store |
| reqPriv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| reqModPriv | input | 1 | Machine data accesses use `reqPrevPriv` |
| reqPrevPriv | input | 2 | Privilege used under the override |
| reqSum | input | 1 | Supervisor may load/store user pages |
| reqMxr | input | 1 | Executable pages are readable |
| reqXlate | input | 1 | 1 translate, 0 bare pass-through |
| reqRootPpn | input | 22 | Root table page number |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 compare-and-swap, 0 read |
| memAddr | output | 34 | Entry byte address |
| memWdata | output | 32 | New entry value for compare-and-swap |
| memCmp | output | 32 | Expected entry value for compare-and-swap |
| memAck | input | 1 | Memory response strobe |
| memRdata | input | 32 | Entry value found by the memory |
| memErr | input | 1 | Memory error with the response |
| rspValid | output | 1 | Response strobe, one cycle |
| rspPaddr | output | 34 | Physical address |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspExec | output | 1 | Execute permitted |
| rspFault | output | 1 | Translation fault |

## Verification
Two functions can fall in the same memory cycle: the walker's accessed/dirty write-back, and a change to that entry by another agent. The bench memory provokes this by replacing the entry with a different page number at the moment the compare-and-swap arrives. The swap then fails and the walker must walk again. This is judged by three results: the response carries the new page number, the memory holds the other agent's value with no write from the walker, and exactly five memory transactions took place (two reads, the failed swap, two reads).

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_UPDATE,
    ST_RESP
  } walkState_t;

  typedef enum logic [1:0] {
    VD_FAULT,
    VD_DESCEND,
    VD_UPDATE,
    VD_DONE
  } verdict_t;

  typedef struct packed {
    logic capture;
    logic latchPte;
    logic descend;
    logic restart;
    logic commit;
    logic markFault;
  } walkStrobe_t;

  localparam int FLAG_V  = 0;
  localparam int FLAG_R  = 1;
  localparam int FLAG_W  = 2;
  localparam int FLAG_X  = 3;
  localparam int FLAG_U  = 4;
  localparam int FLAG_A  = 6;
  localparam int FLAG_D  = 7;
  localparam int PPN_LSB = 10;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        passNow,
  input  logic        memAck,
  input  logic        memErr,
  input  verdict_t    verdict,
  input  logic        casMismatch,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        rspValid,
  output logic        reqReady
);

  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    rspValid  = 1'b0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.capture = 1'b1;
          nextState    = passNow ? ST_RESP : ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.markFault = 1'b1;
            nextState      = ST_RESP;
          end else begin
            strb.latchPte = 1'b1;
            nextState     = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        unique case (verdict)
          VD_FAULT: begin
            strb.markFault = 1'b1;
            nextState      = ST_RESP;
          end
          VD_DESCEND: begin
            strb.descend = 1'b1;
            nextState    = ST_READ;
          end
          VD_UPDATE: nextState = ST_UPDATE;
          default:   nextState = ST_RESP;
        endcase
      end
      ST_UPDATE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.markFault = 1'b1;
            nextState      = ST_RESP;
          end else if (casMismatch) begin
            strb.restart = 1'b1;
            nextState    = ST_READ;
          end else begin
            strb.commit = 1'b1;
            nextState   = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R10: a compare-and-swap only ever follows a leaf check
  p_swap_after_check_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(state) == ST_CHECK);

  // R1: response is a single pulse and the walker is ready afterwards
  p_single_resp_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

endmodule

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  parameter int PTE_W  = 32,
  localparam int PPN_W = PTE_W - PPN_LSB,
  localparam int PA_W  = PPN_W + OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqPriv,
  input  logic              reqModPriv,
  input  logic [1:0]        reqPrevPriv,
  input  logic              reqSum,
  input  logic              reqMxr,
  input  logic              reqXlate,
  input  logic [PPN_W-1:0]  reqRootPpn,
  output logic              passNow,
  output verdict_t          verdict,
  output logic              casMismatch,
  output logic [PA_W-1:0]   memAddr,
  output logic [PTE_W-1:0]  memWdata,
  output logic [PTE_W-1:0]  memCmp,
  input  logic [PTE_W-1:0]  memRdata,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic              rspFault
);

  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  logic [VA_W-1:0]  vaR;
  logic [1:0]       accR, effR;
  logic             sumR, mxrR, faultR, passR;
  logic [PPN_W-1:0] rootR, baseR;
  logic [LVL_W-1:0] levelR;
  logic [PTE_W-1:0] pteR, updPte;

  logic [1:0] reqEff;
  always_comb begin
    reqEff = reqPriv;
    if (reqPriv == PRIV_M && reqAccess != ACC_FETCH && reqModPriv) reqEff = reqPrevPriv;
  end
  assign passNow = !reqXlate || (reqEff == PRIV_M);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR <= '0; accR <= '0; effR <= '0; sumR <= 1'b0; mxrR <= 1'b0;
      rootR <= '0; baseR <= '0; levelR <= '0; pteR <= '0;
      faultR <= 1'b0; passR <= 1'b0;
    end else begin
      if (strb.capture) begin
        vaR    <= reqVaddr;
        accR   <= reqAccess;
        effR   <= reqEff;
        sumR   <= reqSum;
        mxrR   <= reqMxr;
        rootR  <= reqRootPpn;
        baseR  <= reqRootPpn;
        levelR <= TOP_LVL;
        faultR <= 1'b0;
        passR  <= passNow;
      end
      if (strb.latchPte) pteR <= memRdata;
      if (strb.descend) begin
        baseR  <= pteR[PTE_W-1:PPN_LSB];
        levelR <= levelR - LVL_W'(1);
      end
      if (strb.restart) begin
        baseR  <= rootR;
        levelR <= TOP_LVL;
      end
      if (strb.commit)    pteR   <= updPte;
      if (strb.markFault) faultR <= 1'b1;
    end
  end

  // entry address from base and the index field of the current level
  int unsigned shiftBits;
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] lowMask;
  assign shiftBits = int'(levelR) * IDX_W;
  assign idx       = IDX_W'(vaR >> (OFF_W + shiftBits));
  assign lowMask   = PPN_W'((64'd1 << shiftBits) - 64'd1);
  assign memAddr   = {baseR, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SH);

  // flag decode
  logic pV, pR, pW, pX, pU, pD;
  logic [PPN_W-1:0] ppn;
  assign pV  = pteR[FLAG_V];
  assign pR  = pteR[FLAG_R];
  assign pW  = pteR[FLAG_W];
  assign pX  = pteR[FLAG_X];
  assign pU  = pteR[FLAG_U];
  assign pD  = pteR[FLAG_D];
  assign ppn = pteR[PTE_W-1:PPN_LSB];

  logic unusedFlags;
  assign unusedFlags = ^pteR[PPN_LSB-1:FLAG_U+1];

  logic isStore;
  assign isStore = (accR == ACC_STORE);

  always_comb begin
    updPte = pteR;
    updPte[FLAG_A] = 1'b1;
    if (isStore) updPte[FLAG_D] = 1'b1;
  end
  assign memWdata    = updPte;
  assign memCmp      = pteR;
  assign casMismatch = (memRdata != pteR);

  logic accOk;
  always_comb begin
    unique case (accR)
      ACC_LOAD:  accOk = pR || (pX && mxrR);
      ACC_STORE: accOk = pW;
      ACC_FETCH: accOk = pX;
      default:   accOk = 1'b0;
    endcase
  end

  always_comb begin
    if (!pV)                                                  verdict = VD_FAULT;
    else if (!pR && !pW && !pX)                               verdict = (levelR == '0) ? VD_FAULT : VD_DESCEND;
    else if (pW && !pR)                                       verdict = VD_FAULT;
    else if (pU && effR != PRIV_U && (!sumR || accR == ACC_FETCH)) verdict = VD_FAULT;
    else if (!pU && effR != PRIV_S)                           verdict = VD_FAULT;
    else if ((ppn & lowMask) != '0)                           verdict = VD_FAULT;
    else if (!accOk)                                          verdict = VD_FAULT;
    else if (updPte != pteR)                                  verdict = VD_UPDATE;
    else                                                      verdict = VD_DONE;
  end

  // response
  logic [PPN_W-1:0] vpnExt, leafPpn;
  logic leafOk;
  assign vpnExt  = PPN_W'(vaR[VA_W-1:OFF_W]);
  assign leafPpn = (ppn & ~lowMask) | (vpnExt & lowMask);
  assign leafOk  = !passR && !faultR;

  always_comb begin
    if (passR)       rspPaddr = PA_W'(vaR);
    else if (faultR) rspPaddr = '0;
    else             rspPaddr = {leafPpn, vaR[OFF_W-1:0]};
  end
  assign rspRead  = passR || (leafOk && (pR || (pX && mxrR)));
  assign rspExec  = passR || (leafOk && pX);
  assign rspWrite = passR || (leafOk && pW && (isStore || pD));
  assign rspFault = faultR;

  // R5: only a non-final level may be left through a pointer
  p_descend_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.descend |-> levelR != '0);

  // R10: a restart is only taken when the swap found a different entry
  p_restart_on_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |-> casMismatch);

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2,
  parameter int PTE_W  = 32,
  localparam int PPN_W = PTE_W - PPN_LSB,
  localparam int PA_W  = PPN_W + OFF_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             reqModPriv,
  input  logic [1:0]       reqPrevPriv,
  input  logic             reqSum,
  input  logic             reqMxr,
  input  logic             reqXlate,
  input  logic [PPN_W-1:0] reqRootPpn,
  output logic             memReq,
  output logic             memWe,
  output logic [PA_W-1:0]  memAddr,
  output logic [PTE_W-1:0] memWdata,
  output logic [PTE_W-1:0] memCmp,
  input  logic             memAck,
  input  logic [PTE_W-1:0] memRdata,
  input  logic             memErr,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspRead,
  output logic             rspWrite,
  output logic             rspExec,
  output logic             rspFault
);

  walkStrobe_t strb;
  verdict_t    verdict;
  logic        passNow, casMismatch;

  pgwalk_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .passNow, .memAck, .memErr,
    .verdict, .casMismatch, .strb, .memReq, .memWe, .rspValid, .reqReady
  );

  pgwalk_dp #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .PTE_W(PTE_W)
  ) u_dp (
    .clk, .rstN, .strb, .reqVaddr, .reqAccess, .reqPriv, .reqModPriv,
    .reqPrevPriv, .reqSum, .reqMxr, .reqXlate, .reqRootPpn, .passNow,
    .verdict, .casMismatch, .memAddr, .memWdata, .memCmp, .memRdata,
    .rspPaddr, .rspRead, .rspWrite, .rspExec, .rspFault
  );

  // R4: a request is held with a steady address until acknowledged
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R10: a swap always sets the accessed bit and changes the entry
  p_swap_shape_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[FLAG_A] && (memWdata != memCmp));

  // R12: a fault carries no permissions and no address
  p_fault_clean_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> !rspRead && !rspWrite && !rspExec && rspPaddr == '0);

endmodule

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;

  localparam logic [1:0] FETCH = 2'd0, LOAD = 2'd1, STORE = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FA = 8'h40, FD = 8'h80;
  localparam logic [21:0] ROOT = 22'h00100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0] reqAccess = '0, reqPriv = '0, reqPrevPriv = '0;
  logic reqModPriv = 1'b0, reqSum = 1'b0, reqMxr = 1'b0, reqXlate = 1'b1;
  logic [21:0] reqRootPpn = ROOT;
  logic memReq, memWe;
  logic [33:0] memAddr;
  logic [31:0] memWdata, memCmp;
  logic memAck = 1'b0, memErr = 1'b0;
  logic [31:0] memRdata = '0;
  logic rspValid, rspRead, rspWrite, rspExec, rspFault;
  logic [33:0] rspPaddr;

  always #4 clk = ~clk;

  pgwalk uut (
    .clk, .rstN, .reqValid, .reqReady, .reqVaddr, .reqAccess, .reqPriv,
    .reqModPriv, .reqPrevPriv, .reqSum, .reqMxr, .reqXlate, .reqRootPpn,
    .memReq, .memWe, .memAddr, .memWdata, .memCmp, .memAck, .memRdata,
    .memErr, .rspValid, .rspPaddr, .rspRead, .rspWrite, .rspExec, .rspFault
  );

  int nChecks = 0;
  int nErr = 0;
  int txCount = 0;
  int casCount = 0;

  // memory model with compare-and-swap and injected races/errors
  logic [31:0] mem [logic [33:0]];
  logic [33:0] errAddr = '1;
  logic [33:0] raceAddr = '1;
  logic [31:0] raceVal = '0;
  bit raceArmed = 1'b0;

  always @(posedge clk) begin
    logic [31:0] cur;
    if (memAck) begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else if (memReq) begin
      txCount++;
      cur = mem.exists(memAddr) ? mem[memAddr] : 32'h0;
      if (memWe) begin
        if (raceArmed && memAddr == raceAddr) begin
          cur = raceVal;
          mem[memAddr] = raceVal;
          raceArmed = 1'b0;
        end
        if (cur == memCmp) begin
          mem[memAddr] = memWdata;
          casCount++;
        end
      end
      memAck   <= 1'b1;
      memErr   <= (memAddr == errAddr);
      memRdata <= cur;
    end
  end

  function automatic logic [31:0] mkPte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction
  function automatic logic [33:0] l1a(input int v);
    return ({12'h0, ROOT} << 12) + 34'(v * 4);
  endfunction
  function automatic logic [33:0] t0a(input int i);
    return 34'h000200000 + 34'(i * 4);
  endfunction

  typedef struct {
    logic [33:0] pa;
    logic [3:0]  rwxf;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t curExp;

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      nChecks++;
      if (sb.size() == 0) begin
        nErr++;
        $display("FAIL R1 unexpected response: paddr=%h rwxf=%b expected none",
                 rspPaddr, {rspRead, rspWrite, rspExec, rspFault});
      end else begin
        curExp = sb.pop_front();
        if (rspPaddr !== curExp.pa ||
            {rspRead, rspWrite, rspExec, rspFault} !== curExp.rwxf) begin
          nErr++;
          $display("FAIL %s: paddr=%h rwxf=%b expected paddr=%h rwxf=%b", curExp.tag,
                   rspPaddr, {rspRead, rspWrite, rspExec, rspFault}, curExp.pa, curExp.rwxf);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
                    input logic [33:0] pa, input logic [3:0] rwxf, input string tag);
    exp_t e;
    e.pa = pa; e.rwxf = rwxf; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqVaddr = va; reqAccess = acc; reqPriv = priv; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic goFault(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] priv,
                         input string tag);
    go(va, acc, priv, 34'h0, 4'b0001, {tag, " R12"});
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    int t;
    mem[l1a(1)] = mkPte(22'h00200, FV);
    mem[t0a(1)] = mkPte(22'h12345, FV | FR | FW | FA);
    mem[l1a(2)] = mkPte(22'h00C00, FV | FR | FX | FA);
    mem[l1a(3)] = mkPte(22'h00C01, FV | FR | FA);
    mem[l1a(5)] = mkPte(22'h00201, FV);
    mem[34'h000201000] = mkPte(22'h00202, FV);
    mem[t0a(2)] = mkPte(22'h00050, FV | FW);
    mem[t0a(3)] = mkPte(22'h00051, FV | FW | FX);
    mem[t0a(4)] = mkPte(22'h00300, FV | FR | FX | FU | FA);
    mem[t0a(5)] = mkPte(22'h00301, FV | FX | FA);
    mem[t0a(6)] = mkPte(22'h00302, FV | FR | FA);
    mem[t0a(7)] = mkPte(22'h00303, FV | FR | FW);
    mem[t0a(8)] = mkPte(22'h00400, FV | FR);
    mem[l1a(6)] = mkPte(22'h00210, FV);
    for (int i = 0; i < 8; i++) mem[34'h000210000 + 34'(i * 4)] = 32'h0;

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 reset ready", 64'(reqReady), 64'd1);
    chk(rspValid == 1'b0, "R1 reset rspValid", 64'(rspValid), 64'd0);
    chk(memReq == 1'b0, "R1 reset memReq", 64'(memReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 bare and machine pass-through
    reqXlate = 1'b0;
    t = txCount;
    go(32'h12345678, LOAD, PS, 34'h012345678, 4'b1110, "R2 bare pass-through");
    chk(txCount == t, "R2 bare no memory access", 64'(txCount), 64'(t));
    reqXlate = 1'b1;
    t = txCount;
    go(32'h00401abc, LOAD, PM, 34'h000401abc, 4'b1110, "R2 machine pass-through");
    chk(txCount == t, "R2 machine no memory access", 64'(txCount), 64'(t));

    // R3 modify-privilege override
    reqModPriv = 1'b1; reqPrevPriv = PS;
    go(32'h00401abc, FETCH, PM, 34'h000401abc, 4'b1110, "R3 fetch ignores override");
    go(32'h00401abc, LOAD, PM, 34'h012345abc, 4'b1000, "R3 machine load as supervisor");
    reqModPriv = 1'b0;

    // R4 R11 two-level 4K page
    go(32'h00401abc, LOAD, PS, 34'h012345abc, 4'b1000, "R4 R11 4K load");
    t = casCount;
    go(32'h00401abc, STORE, PS, 34'h012345abc, 4'b1100, "R10 store sets dirty");
    chk(mem[t0a(1)] == mkPte(22'h12345, FV | FR | FW | FA | FD), "R10 dirty written",
        64'(mem[t0a(1)]), 64'(mkPte(22'h12345, FV | FR | FW | FA | FD)));
    chk(casCount == t + 1, "R10 one swap for store", 64'(casCount), 64'(t + 1));
    go(32'h00401abc, LOAD, PS, 34'h012345abc, 4'b1100, "R11 write granted when dirty");
    go(32'h00401abc, STORE, PS, 34'h012345abc, 4'b1100, "R10 store on dirty page");
    chk(casCount == t + 1, "R10 no swap when bits set", 64'(casCount), 64'(t + 1));

    // R11 superpage, R8 misaligned
    go(32'h00800123, FETCH, PS, 34'h000C00123, 4'b1010, "R11 superpage fetch");
    goFault(32'h00C00000, LOAD, PS, "R8 misaligned superpage");

    // R5 faults
    goFault(32'h01000000, LOAD, PS, "R5 invalid entry");
    goFault(32'h01400000, LOAD, PS, "R5 pointer at last level");
    errAddr = l1a(6);
    goFault(32'h01800000, LOAD, PS, "R5 memory error");
    errAddr = '1;

    // R6 reserved leaves
    goFault(32'h00402000, STORE, PS, "R6 write-only leaf");
    goFault(32'h00403000, FETCH, PS, "R6 write-execute leaf");

    // R7 user/supervisor
    goFault(32'h00404010, LOAD, PS, "R7 user page without SUM");
    reqSum = 1'b1;
    go(32'h00404010, LOAD, PS, 34'h000300010, 4'b1010, "R7 user page with SUM");
    goFault(32'h00404010, FETCH, PS, "R7 user page fetch with SUM");
    reqSum = 1'b0;
    goFault(32'h00401abc, LOAD, PU, "R7 supervisor page from user");
    go(32'h00404010, LOAD, PU, 34'h000300010, 4'b1010, "R7 user page from user");

    // R9 access rights
    goFault(32'h00405008, LOAD, PS, "R9 execute-only load without MXR");
    reqMxr = 1'b1;
    go(32'h00405008, LOAD, PS, 34'h000301008, 4'b1010, "R9 execute-only load with MXR");
    reqMxr = 1'b0;
    goFault(32'h00406000, STORE, PS, "R9 store to read-only");
    goFault(32'h00401abc, FETCH, PS, "R9 fetch from non-executable");

    // R10 accessed bit
    t = casCount;
    go(32'h00407000, LOAD, PS, 34'h000303000, 4'b1000, "R10 load sets accessed");
    chk(mem[t0a(7)] == mkPte(22'h00303, FV | FR | FW | FA), "R10 accessed written",
        64'(mem[t0a(7)]), 64'(mkPte(22'h00303, FV | FR | FW | FA)));
    chk(casCount == t + 1, "R10 one swap for load", 64'(casCount), 64'(t + 1));

    // R10 race: entry replaced when the swap arrives
    t = casCount;
    raceAddr = t0a(8);
    raceVal = mkPte(22'h00401, FV | FR | FA);
    raceArmed = 1'b1;
    begin
      int tx0;
      tx0 = txCount;
      go(32'h00408000, LOAD, PS, 34'h000401000, 4'b1000, "R10 restart after changed entry");
      chk(txCount - tx0 == 5, "R10 rewalk transactions", 64'(txCount - tx0), 64'd5);
    end
    chk(mem[t0a(8)] == raceVal, "R10 racer value kept", 64'(mem[t0a(8)]), 64'(raceVal));
    chk(casCount == t, "R10 failed swap not written", 64'(casCount), 64'(t));

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule